// File: doc/BRIEF.md
# Round-Robin Voice Interrupt Arbiter

This block collects two kinds of interrupt flag, wave-boundary and volume-ramp, for a bank of synthesizer voices and hands them to the host one voice at a time. Each voice raises its flags through one-cycle set strobes. A programmable active-voice count limits which voices take part. A round-robin pointer names the voice that is reported next.

The host sees a global status byte that summarises pending activity, plus an interrupt line gated by an enable bit from the mix-control register. The host services voices by reading a per-voice source byte. That read is destructive: it clears both flags of the reported voice, and the pointer then moves to the next pending voice. The search for that voice is a single-cycle combinational priority scan.

Top module: `voice_irq_arbiter`

## Requirements
- R1: After reset all voice flags are clear, the pointer is voice 0, the active count is 14, `status` is 0x00, `irq` is 0 and `src_data` reads 0xE0.
- R2: A `wave_set` or `ramp_set` strobe bit sets that voice's flag at the next clock edge. `status` bit 5 is 1 while any active voice has a wave flag pending, and bit 6 is 1 while any active voice has a ramp flag pending. All other `status` bits are 0.
- R3: A write on `cnt_wr` sets the active count to 1 + (`cnt_wdata` & 63), clamped to the range 14 to 32. Bits 7:6 of the written value are ignored. Voices with an index at or above the count take part neither in `status` nor in reporting.
- R4: In `src_data`, bits 4:0 give the reported voice index and bit 5 is always 1. Bit 6 is 1 when that voice's ramp flag is NOT pending, and bit 7 is 1 when its wave flag is NOT pending.
- R5: When any active voice is pending, the reported voice is the first pending voice found when searching upward from the current pointer (the pointer itself included), wrapping from count-1 to voice 0. When no active voice is pending, the pointer keeps its value.
- R6: A cycle with `src_rd` high clears both flags of the voice shown in `src_data` during that cycle. The next report rescans from that voice.
- R7: When a set strobe and a read-clear hit the same voice's flag in the same cycle, the set wins and the flag stays pending.
- R8: `irq` is 1 exactly when `irq_en` is 1 and `status` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_set | input | NUM_VOICES | Per-voice wave-boundary flag set strobes |
| ramp_set | input | NUM_VOICES | Per-voice volume-ramp flag set strobes |
| cnt_wr | input | 1 | Active-voice count write strobe |
| cnt_wdata | input | 8 | Value written to the active-voice count |
| src_rd | input | 1 | Destructive read strobe for the source byte |
| irq_en | input | 1 | Interrupt enable from mix control |
| status | output | 8 | Global status byte (bit 6 ramp, bit 5 wave) |
| src_data | output | 8 | Source byte: voice index and active-low cause bits |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with the defaults, 32 voices and a minimum count of 14. These values put both ends of the clamp within reach: a written count of 1 or 13 raises to 14, and a written count of 64 drops to 32. At 32 voices the highest voice, index 31, and the full five-bit index field can be exercised. With the reset count of 14, the round-robin wrap happens early, so a search that starts at voice 9 and lands on voice 1 shows the wrap within a few cycles. The bench also uses voices at index 14 and above to show that flags on inactive voices are held but not reported.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;

  // Active count from a written byte: 1 + low six bits, limited to [lo, hi].
  function automatic logic [6:0] clamp_count(input logic [7:0] wr, input logic [6:0] lo,
                                             input logic [6:0] hi);
    logic [6:0] raw;
    raw = {1'b0, wr[5:0]} + 7'd1;
    if (raw < lo) raw = lo;
    if (raw > hi) raw = hi;
    return raw;
  endfunction

  // Source byte: inverted wave, inverted ramp, fixed one, voice index.
  function automatic logic [7:0] cause_byte(input logic [4:0] idx, input logic wave_p,
                                            input logic ramp_p);
    return {~wave_p, ~ramp_p, 1'b1, idx};
  endfunction

endpackage

// File: rtl/vi_count_reg.sv
module vi_count_reg #(
  parameter int NV   = 32,
  parameter int MINV = 14,
  localparam int CW  = $clog2(NV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] cnt_q,
  output logic [NV-1:0] act_mask
);
  import voice_irq_pkg::*;

  logic [6:0] cnt_next;
  assign cnt_next = clamp_count(wdata, 7'(MINV), 7'(NV));

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt_q <= CW'(MINV);
    else if (wr) cnt_q <= CW'(cnt_next);
  end

  for (genvar i = 0; i < NV; i++) begin : g_mask
    assign act_mask[i] = (cnt_q > CW'(i));
  end
endmodule

// File: rtl/vi_flag_bank.sv
module vi_flag_bank #(
  parameter int NV = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] set_v,
  input  logic [NV-1:0] clr_v,
  output logic [NV-1:0] flag_q
);
  for (genvar i = 0; i < NV; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;
      else if (clr_v[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vi_rr_scan.sv
module vi_rr_scan #(
  parameter int NV  = 32,
  localparam int IW = $clog2(NV),
  localparam int CW = $clog2(NV + 1)
) (
  input  logic [NV-1:0] pend,
  input  logic [IW-1:0] ptr,
  input  logic [CW-1:0] cnt,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);
  int start;
  int lim;

  always_comb begin
    lim   = int'(cnt);
    start = (int'(ptr) >= lim) ? 0 : int'(ptr);
    hit     = 1'b0;
    hit_idx = IW'(start);
    for (int k = 0; k < NV; k++) begin
      int idx;
      idx = start + k;
      if (idx >= lim) idx = idx - lim;
      if (k < lim) begin
        if (!hit && pend[idx]) begin
          hit     = 1'b1;
          hit_idx = IW'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/voice_irq_arbiter.sv
module voice_irq_arbiter #(
  parameter int NUM_VOICES = 32,
  parameter int MIN_ACTIVE = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VOICES-1:0] wave_set,
  input  logic [NUM_VOICES-1:0] ramp_set,
  input  logic                  cnt_wr,
  input  logic [7:0]            cnt_wdata,
  input  logic                  src_rd,
  input  logic                  irq_en,
  output logic [7:0]            status,
  output logic [7:0]            src_data,
  output logic                  irq
);
  import voice_irq_pkg::*;

  localparam int IW = $clog2(NUM_VOICES);
  localparam int CW = $clog2(NUM_VOICES + 1);

  logic [CW-1:0]         cnt_q;
  logic [NUM_VOICES-1:0] act_mask;
  logic [NUM_VOICES-1:0] wave_q, ramp_q;
  logic [NUM_VOICES-1:0] pend_act;
  logic [NUM_VOICES-1:0] rd_clr;
  logic [IW-1:0]         ptr_q, cur_ptr, scan_idx;
  logic                  scan_hit;
  logic                  wave_any, ramp_any;

  vi_count_reg #(.NV(NUM_VOICES), .MINV(MIN_ACTIVE)) u_count (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(cnt_wdata),
    .cnt_q(cnt_q), .act_mask(act_mask)
  );

  vi_flag_bank #(.NV(NUM_VOICES)) u_wave (
    .clk(clk), .rst_n(rst_n), .set_v(wave_set), .clr_v(rd_clr), .flag_q(wave_q)
  );

  vi_flag_bank #(.NV(NUM_VOICES)) u_ramp (
    .clk(clk), .rst_n(rst_n), .set_v(ramp_set), .clr_v(rd_clr), .flag_q(ramp_q)
  );

  assign pend_act = (wave_q | ramp_q) & act_mask;

  vi_rr_scan #(.NV(NUM_VOICES)) u_scan (
    .pend(pend_act), .ptr(ptr_q), .cnt(cnt_q), .hit(scan_hit), .hit_idx(scan_idx)
  );

  assign cur_ptr = scan_hit ? scan_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= cur_ptr;
  end

  for (genvar i = 0; i < NUM_VOICES; i++) begin : g_clr
    assign rd_clr[i] = src_rd && (cur_ptr == IW'(i));
  end

  assign wave_any = |(wave_q & act_mask);
  assign ramp_any = |(ramp_q & act_mask);
  assign status   = {1'b0, ramp_any, wave_any, 5'b0};
  assign src_data = cause_byte(5'(cur_ptr), wave_q[cur_ptr], ramp_q[cur_ptr]);
  assign irq      = irq_en && (status != 8'h00);
endmodule

// File: rtl/vi_arbiter_checks.sv
module vi_arbiter_checks #(
  parameter int NV   = 32,
  parameter int MINV = 14,
  localparam int IW  = $clog2(NV),
  localparam int CW  = $clog2(NV + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NV-1:0] wave_set,
  input logic [NV-1:0] ramp_set,
  input logic          src_rd,
  input logic          irq_en,
  input logic [7:0]    status,
  input logic          irq,
  input logic [IW-1:0] cur_ptr,
  input logic [CW-1:0] cnt_q,
  input logic [NV-1:0] wave_q,
  input logic [NV-1:0] ramp_q
);
  assert_wave_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wave_set[0] |=> status[5]);

  assert_ramp_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_set[0] |=> status[6]);

  assert_status_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'h9F) == 8'h00);

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CW'(MINV)) && (cnt_q <= CW'(NV)));

  assert_ptr_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 8'h00) |-> (cur_ptr < IW'(cnt_q)) || (cnt_q == CW'(NV)));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && (wave_set == '0) && (ramp_set == '0))
      |=> !wave_q[$past(cur_ptr)] && !ramp_q[$past(cur_ptr)]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && wave_set[cur_ptr]) |=> wave_q[$past(cur_ptr)]);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (status != 8'h00)));
endmodule

bind voice_irq_arbiter vi_arbiter_checks #(.NV(NUM_VOICES), .MINV(MIN_ACTIVE)) u_checks (
  .clk(clk), .rst_n(rst_n), .wave_set(wave_set), .ramp_set(ramp_set),
  .src_rd(src_rd), .irq_en(irq_en), .status(status), .irq(irq),
  .cur_ptr(cur_ptr), .cnt_q(cnt_q), .wave_q(wave_q), .ramp_q(ramp_q)
);

// File: tb/voice_irq_arbiter_bench.sv
module voice_irq_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] wave_set = '0;
  logic [NV-1:0] ramp_set = '0;
  logic          cnt_wr = 1'b0;
  logic [7:0]    cnt_wdata = '0;
  logic          src_rd = 1'b0;
  logic          irq_en = 1'b0;
  logic [7:0]    status, src_data;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_irq_arbiter #(.NUM_VOICES(NV), .MIN_ACTIVE(14)) u_voice_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .wave_set(wave_set), .ramp_set(ramp_set),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .src_rd(src_rd), .irq_en(irq_en),
    .status(status), .src_data(src_data), .irq(irq)
  );

  // op: 0 = wave set (check status), 1 = ramp set (check status), 2 = read (check byte)
  localparam logic [17:0] VEC [0:12] = '{
    {2'd0, 8'd3, 8'h20}, {2'd1, 8'd5, 8'h60}, {2'd2, 8'd0, 8'h63},
    {2'd2, 8'd0, 8'hA5}, {2'd2, 8'd0, 8'hE5}, {2'd0, 8'd9, 8'h20},
    {2'd0, 8'd1, 8'h20}, {2'd2, 8'd0, 8'h69}, {2'd2, 8'd0, 8'h61},
    {2'd0, 8'd4, 8'h20}, {2'd1, 8'd4, 8'h60}, {2'd2, 8'd0, 8'h24},
    {2'd2, 8'd0, 8'hE4}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic set_wave(input int v);
    wave_set[v] = 1'b1;
    @(negedge clk);
    wave_set = '0;
  endtask

  task automatic set_ramp(input int v);
    ramp_set[v] = 1'b1;
    @(negedge clk);
    ramp_set = '0;
  endtask

  task automatic read_src(output logic [7:0] b);
    src_rd = 1'b1;
    #1 b = src_data;
    @(negedge clk);
    src_rd = 1'b0;
  endtask

  task automatic write_cnt(input logic [7:0] v);
    cnt_wr = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 src_data", src_data, 8'hE0);

    // Table walk: R2 status, R4 byte format, R5 round-robin order and wrap at 14, R6 clearing
    for (int i = 0; i < 13; i++) begin
      logic [17:0] e;
      e = VEC[i];
      case (e[17:16])
        2'd0: begin set_wave(int'(e[15:8])); check("R2 wave status", status, e[7:0]); end
        2'd1: begin set_ramp(int'(e[15:8])); check("R2 ramp status", status, e[7:0]); end
        default: begin read_src(b); check("R4/R5/R6 source byte", b, e[7:0]); end
      endcase
    end

    // R8 interrupt gating
    irq_en = 1'b0;
    set_wave(0);
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 check("R8 irq enabled", {7'b0, irq}, 8'h01);
    read_src(b);
    check("R5 pointer wraps to voice 0", b, 8'h60);
    check("R8 irq drops after clear", {7'b0, irq}, 8'h00);

    // R7 set beats read-clear on the same voice
    set_wave(2);
    wave_set[2] = 1'b1;
    src_rd = 1'b1;
    #1 b = src_data;
    @(negedge clk);
    wave_set = '0;
    src_rd = 1'b0;
    check("R7 read byte", b, 8'h62);
    check("R7 flag kept", status, 8'h20);
    read_src(b);
    check("R6 second read", b, 8'h62);
    check("R6 cleared", status, 8'h00);

    // R3 clamping and inactive voices
    write_cnt(8'h00);
    set_wave(20);
    check("R3 inactive voice hidden", status, 8'h00);
    read_src(b);
    check("R5 pointer held with nothing pending", b, 8'hE2);
    write_cnt(8'h14);
    check("R3 count 21 exposes voice 20", status, 8'h20);
    read_src(b);
    check("R3 voice 20 reported", b, 8'h74);
    write_cnt(8'h0C);
    set_wave(13);
    check("R3 low clamp keeps voice 13", status, 8'h20);
    read_src(b);
    check("R3 voice 13 reported", b, 8'h6D);
    set_wave(14);
    check("R3 voice 14 inactive at 14", status, 8'h00);
    write_cnt(8'h0E);
    check("R3 count 15", status, 8'h20);
    read_src(b);
    check("R3 voice 14 reported", b, 8'h6E);
    write_cnt(8'hFF);
    set_ramp(31);
    check("R3 high clamp 32", status, 8'h40);
    read_src(b);
    check("R3 voice 31 reported", b, 8'hBF);
    write_cnt(8'h40);
    set_wave(15);
    check("R3 upper bits ignored", status, 8'h00);
    write_cnt(8'h0F);
    read_src(b);
    check("R3 voice 15 reported", b, 8'h6F);

    summary();
  end
endmodule